// File: doc/BRIEF.md
# I2C Slave Transmit Status Engine

This block is the read-side slave of an I2C controller. It watches the bus lines through a synchroniser and detects START and STOP. It takes in the 8-bit address byte and acknowledges it only when the top seven bits match the configured own address and the direction bit requests a read. It then shifts bytes from a software-loaded data register onto SDA, most significant bit first, and samples the acknowledge bit that the master returns after each byte.

Each completed step raises an interrupt flag and presents an 8-bit hexadecimal status code. While the flag is up, the engine holds SCL low. Software answers by writing the next data byte and pulsing a flag-clear strobe, and the clock is then released. An acknowledge-enable input decides whether the engine answers its address at all. The same input also marks the byte being loaded as the final one. After that final byte the engine drops back to the not-addressed state, so a master that keeps clocking reads only ones.

Top module: `i2c_stx_engine`

## Requirements
- R1: A START, then an address byte whose upper 7 bits equal `own_addr` with bit 0 = 1 (read), with `ack_en` = 1, is answered by SDA low during the 9th clock. Any other address, a write (bit 0 = 0), or the all-zero broadcast address gets no acknowledge and leaves `si` at 0.
- R2: After its own address with read is acknowledged, `si` goes to 1 at the falling edge of the 9th clock and `status` reads 8'hA8.
- R3: If `mst_arb_lost` is 1 at that falling edge, the status code is 8'hB0 instead of 8'hA8.
- R4: Each data byte appears on SDA most significant bit first and equals the value written through `dat_we`/`dat_wdata` before the flag was cleared. If the master acknowledges and `ack_en` was 1 when the flag was cleared, the status is 8'hB8.
- R5: If the master does not acknowledge a data byte, the status is 8'hC0, whatever `ack_en` was.
- R6: If `ack_en` was 0 when the flag was cleared before a byte, and the master acknowledges that byte, the status is 8'hC8.
- R7: Clearing the flag at status 8'hC0 or 8'hC8 releases SDA and SCL. Further master clocks then read 8'hFF, and `si` stays 0 until a new START addresses the block.
- R8: While `ack_en` is 0 the own address is not acknowledged, but START detection continues. Setting `ack_en` and issuing a repeated START (no STOP) gets the address acknowledged.
- R9: Whenever `si` is 0, `status` reads 8'hF8.
- R10: SCL is pulled low only while `si` is 1, and is released once `si_clr` is pulsed.
- R11: After reset, `si` = 0, `status` = 8'hF8 and neither line is pulled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| own_addr | input | DATA_W-1 | Own 7-bit slave address |
| ack_en | input | 1 | Acknowledge enable / more-bytes indicator |
| mst_arb_lost | input | 1 | Sibling master lost arbitration in this address byte |
| dat_we | input | 1 | Write strobe for the transmit data register |
| dat_wdata | input | DATA_W | Transmit data value |
| si_clr | input | 1 | Pulse to clear the interrupt flag |
| si | output | 1 | Interrupt flag |
| status | output | 8 | Status code |

## Verification
A corrupted state register or bit counter shows at the ports within one byte time. Depending on the fault, the address acknowledge is missing or misplaced, a data byte is shifted by a bit, or the flag rises with the wrong code at the 9th falling edge. A stuck flag or final-byte marker shows as SCL held low after the clear strobe, or as SDA pulled low when the master expects all ones after the last byte. Both are visible within the next bus clock.

// File: rtl/stx_pkg.sv
`timescale 1ns/1ps
package stx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,   // not addressed, monitoring for START
    ST_ADDR,   // taking in the address byte
    ST_AACK,   // pulling SDA low for the address acknowledge
    ST_HOLD,   // flag raised, SCL held low
    ST_SEND,   // shifting a data byte out
    ST_MACK    // master acknowledge slot
  } stx_state_t;

  localparam logic [7:0] CODE_IDLE      = 8'hF8;
  localparam logic [7:0] CODE_ADDR_RD   = 8'hA8;
  localparam logic [7:0] CODE_ARB_RD    = 8'hB0;
  localparam logic [7:0] CODE_DATA_ACK  = 8'hB8;
  localparam logic [7:0] CODE_DATA_NACK = 8'hC0;
  localparam logic [7:0] CODE_LAST_ACK  = 8'hC8;
endpackage

// File: rtl/stx_bus_mon.sv
`timescale 1ns/1ps
module stx_bus_mon #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_STAGES-1:0] scl_ff, sda_ff, scl_ff_d, sda_ff_d;
  logic scl_q, sda_q;

  // next values of the synchroniser chains
  always_comb begin
    scl_ff_d = {scl_ff[SYNC_STAGES-2:0], scl_i};
    sda_ff_d = {sda_ff[SYNC_STAGES-2:0], sda_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= scl_ff_d;
      sda_ff <= sda_ff_d;
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  assign scl_s     = scl_ff[SYNC_STAGES-1];
  assign sda_s     = sda_ff[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/stx_shifter.sv
`timescale 1ns/1ps
module stx_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_clr,
  input  logic              cap_en,
  input  logic              sda_s,
  input  logic              load_en,
  input  logic [DATA_W-1:0] load_data,
  input  logic              shift_en,
  output logic [DATA_W-1:0] sh_byte,
  output logic              tx_msb,
  output logic [$clog2(DATA_W+1)-1:0] bit_cnt
);
  localparam int CNT_W = $clog2(DATA_W + 1);

  logic [DATA_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;

  // one register serves both the incoming address and the outgoing data
  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    if (cnt_clr) begin
      cnt_d = '0;
    end else if (load_en) begin
      sh_d  = load_data;
      cnt_d = '0;
    end else if (cap_en) begin
      sh_d  = {sh_q[DATA_W-2:0], sda_s};
      cnt_d = cnt_q + 1'b1;
    end else if (shift_en) begin
      sh_d  = {sh_q[DATA_W-2:0], 1'b1};
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '1;
      cnt_q <= '0;
    end else begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
    end
  end

  assign sh_byte = sh_q;
  assign tx_msb  = sh_q[DATA_W-1];
  assign bit_cnt = cnt_q;

  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DATA_W));
endmodule

// File: rtl/stx_ctrl.sv
`timescale 1ns/1ps
module stx_ctrl
  import stx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              sda_s,
  input  logic [DATA_W-1:0] sh_byte,
  input  logic [$clog2(DATA_W+1)-1:0] bit_cnt,
  input  logic              tx_msb,
  input  logic [DATA_W-2:0] own_addr,
  input  logic              ack_en,
  input  logic              mst_arb_lost,
  input  logic              si_clr,
  output logic              cnt_clr,
  output logic              cap_en,
  output logic              load_en,
  output logic              shift_en,
  output logic              si,
  output logic [7:0]        code,
  output logic              sda_oe,
  output logic              scl_oe
);
  localparam int CNT_W = $clog2(DATA_W + 1);

  stx_state_t state_q, state_d;
  logic       si_q, si_d;
  logic [7:0] code_q, code_d;
  logic       final_q, final_d;
  logic       last_q, last_d;
  logic       ack_q, ack_d;
  logic       addr_hit;

  assign addr_hit = (sh_byte[DATA_W-1:1] == own_addr) && sh_byte[0];

  always_comb begin
    state_d  = state_q;
    si_d     = si_q;
    code_d   = code_q;
    final_d  = final_q;
    last_d   = last_q;
    ack_d    = ack_q;
    cnt_clr  = 1'b0;
    cap_en   = 1'b0;
    load_en  = 1'b0;
    shift_en = 1'b0;
    if (state_q != ST_HOLD && start_det) begin
      state_d = ST_ADDR;
      cnt_clr = 1'b1;
    end else if (state_q != ST_HOLD && stop_det) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: ;
        ST_ADDR: begin
          cap_en = scl_rise;
          if (scl_fall && bit_cnt == CNT_W'(DATA_W))
            state_d = (addr_hit && ack_en) ? ST_AACK : ST_IDLE;
        end
        ST_AACK: begin
          if (scl_fall) begin
            state_d = ST_HOLD;
            si_d    = 1'b1;
            code_d  = mst_arb_lost ? CODE_ARB_RD : CODE_ADDR_RD;
            final_d = 1'b0;
          end
        end
        ST_HOLD: begin
          if (si_clr) begin
            si_d = 1'b0;
            if (final_q) begin
              state_d = ST_IDLE;
            end else begin
              load_en = 1'b1;
              last_d  = ~ack_en;
              state_d = ST_SEND;
            end
          end
        end
        ST_SEND: begin
          shift_en = scl_fall;
          if (scl_fall && bit_cnt == CNT_W'(DATA_W - 1))
            state_d = ST_MACK;
        end
        ST_MACK: begin
          if (scl_rise)
            ack_d = ~sda_s;
          if (scl_fall) begin
            state_d = ST_HOLD;
            si_d    = 1'b1;
            final_d = ~ack_q | last_q;
            if (!ack_q)      code_d = CODE_DATA_NACK;
            else if (last_q) code_d = CODE_LAST_ACK;
            else             code_d = CODE_DATA_ACK;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      si_q    <= 1'b0;
      code_q  <= CODE_IDLE;
      final_q <= 1'b0;
      last_q  <= 1'b0;
      ack_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      si_q    <= si_d;
      code_q  <= code_d;
      final_q <= final_d;
      last_q  <= last_d;
      ack_q   <= ack_d;
    end
  end

  assign si     = si_q;
  assign code   = code_q;
  assign scl_oe = (state_q == ST_HOLD);
  assign sda_oe = (state_q == ST_AACK) | ((state_q == ST_SEND) & ~tx_msb);

  // R10
  hold_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scl_oe |-> si);

  // R10
  flag_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(si) |-> $past(scl_fall));

  // R2
  flag_code_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(si) |-> (code == CODE_ADDR_RD || code == CODE_ARB_RD ||
                   code == CODE_DATA_ACK || code == CODE_DATA_NACK ||
                   code == CODE_LAST_ACK));

  // R7
  final_clear_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (si && si_clr && (code == CODE_DATA_NACK || code == CODE_LAST_ACK))
      |=> (!si && !scl_oe && !sda_oe));

  // R1
  addr_ack_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_AACK) |-> (sh_byte[0] && sh_byte[DATA_W-1:1] == own_addr));
endmodule

// File: rtl/i2c_stx_engine.sv
`timescale 1ns/1ps
module i2c_stx_engine
  import stx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic [DATA_W-2:0] own_addr,
  input  logic              ack_en,
  input  logic              mst_arb_lost,
  input  logic              dat_we,
  input  logic [DATA_W-1:0] dat_wdata,
  input  logic              si_clr,
  output logic              si,
  output logic [7:0]        status
);
  localparam int CNT_W = $clog2(DATA_W + 1);

  logic [1:0] rst_pipe;
  logic       rst_ni;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ni = rst_pipe[1];

  logic [DATA_W-1:0] dat_q, dat_d;
  always_comb dat_d = dat_we ? dat_wdata : dat_q;
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) dat_q <= '0;
    else         dat_q <= dat_d;
  end

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic cnt_clr, cap_en, load_en, shift_en, tx_msb, si_w;
  logic [DATA_W-1:0] sh_byte;
  logic [CNT_W-1:0]  bit_cnt;
  logic [7:0]        code_w;

  stx_bus_mon #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
    .clk(clk), .rst_n(rst_ni), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  stx_shifter #(.DATA_W(DATA_W)) u_sh (
    .clk(clk), .rst_n(rst_ni), .cnt_clr(cnt_clr), .cap_en(cap_en),
    .sda_s(sda_s), .load_en(load_en), .load_data(dat_q), .shift_en(shift_en),
    .sh_byte(sh_byte), .tx_msb(tx_msb), .bit_cnt(bit_cnt)
  );

  stx_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_ni), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .sda_s(sda_s),
    .sh_byte(sh_byte), .bit_cnt(bit_cnt), .tx_msb(tx_msb),
    .own_addr(own_addr), .ack_en(ack_en), .mst_arb_lost(mst_arb_lost),
    .si_clr(si_clr), .cnt_clr(cnt_clr), .cap_en(cap_en), .load_en(load_en),
    .shift_en(shift_en), .si(si_w), .code(code_w), .sda_oe(sda_oe),
    .scl_oe(scl_oe)
  );

  assign si     = si_w;
  assign status = si_w ? code_w : CODE_IDLE;
endmodule

// File: tb/sim_i2c_stx_engine.sv
`timescale 1ns/1ps
module sim_i2c_stx_engine;
  localparam int H = 10;
  localparam logic [6:0] OWN = 7'h3A;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, m_scl, m_sda, scl_oe, sda_oe, ack_en, arb, dat_we, si_clr, si;
  logic [6:0] own_addr;
  logic [7:0] dat_wdata, status;
  logic scl_line, sda_line;
  int n_cmp = 0, n_bad = 0;

  assign scl_line = m_scl & ~scl_oe;
  assign sda_line = m_sda & ~sda_oe;

  i2c_stx_engine u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .own_addr(own_addr), .ack_en(ack_en),
    .mst_arb_lost(arb), .dat_we(dat_we), .dat_wdata(dat_wdata),
    .si_clr(si_clr), .si(si), .status(status)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic hp();
    repeat (H) @(negedge clk);
  endtask

  task automatic wait_high();
    while (scl_line !== 1'b1) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; hp();
    m_scl = 1'b1; wait_high(); hp();
    m_sda = 1'b0; hp();
    m_scl = 1'b0; hp();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; hp();
    m_scl = 1'b1; wait_high(); hp();
    m_sda = 1'b1; hp();
  endtask

  task automatic clk_bit(input logic b, output logic r);
    m_sda = b; hp();
    m_scl = 1'b1; wait_high();
    repeat (H/2) @(negedge clk);
    r = sda_line;
    repeat (H/2) @(negedge clk);
    m_scl = 1'b0; hp();
  endtask

  task automatic send_byte(input logic [7:0] v, output logic acked);
    logic r;
    for (int i = 7; i >= 0; i--) clk_bit(v[i], r);
    clk_bit(1'b1, r);
    acked = ~r;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] v);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, r);
      v[i] = r;
    end
    clk_bit(~mack, r);
  endtask

  task automatic sw_release(input logic [7:0] v, input logic aa);
    dat_wdata = v; dat_we = 1'b1; ack_en = aa;
    @(negedge clk);
    dat_we = 1'b0; si_clr = 1'b1;
    @(negedge clk);
    si_clr = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run did not finish, got 1 expected 0");
    summary();
    $finish;
  end

  initial begin
    logic ak;
    logic [7:0] d, v;
    rst_n = 1'b0; m_scl = 1'b1; m_sda = 1'b1; own_addr = OWN; ack_en = 1'b1;
    arb = 1'b0; dat_we = 1'b0; dat_wdata = 8'h00; si_clr = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R11 reset state
    check("R11 si", 16'(si), 16'd0);
    check("R11 status", 16'(status), 16'hF8);
    check("R11 oe", 16'({scl_oe, sda_oe}), 16'd0);

    // R1 sweep of every address with read direction
    for (int a = 0; a < 128; a++) begin
      bus_start();
      send_byte({7'(a), 1'b1}, ak);
      check("R1 ack on address", 16'(ak), 16'(a == int'(OWN)));
      if (a == int'(OWN)) begin
        check("R2 flag", 16'(si), 16'd1);
        check("R2 status", 16'(status), 16'hA8);
        check("R10 scl held", 16'(scl_oe), 16'd1);
        v = 8'(a * 5 + 3);
        sw_release(v, 1'b0);
        check("R9 status when flag clear", 16'(status), 16'hF8);
        recv_byte(1'b0, d);
        check("R4 byte", 16'(d), 16'(v));
        check("R5 nack status", 16'(status), 16'hC0);
        sw_release(8'h00, 1'b1);
        check("R7 flag after final", 16'(si), 16'd0);
      end else begin
        check("R1 no flag", 16'(si), 16'd0);
        check("R9 idle status", 16'(status), 16'hF8);
      end
      bus_stop();
    end

    // R1 write direction to own address
    bus_start();
    send_byte({OWN, 1'b0}, ak);
    check("R1 write not acked", 16'(ak), 16'd0);
    check("R1 write no flag", 16'(si), 16'd0);
    bus_stop();

    // R4 R6 R10 multi-byte read
    bus_start();
    send_byte({OWN, 1'b1}, ak);
    check("R2 status", 16'(status), 16'hA8);
    repeat (50) @(negedge clk);
    check("R10 scl still low", 16'(scl_line), 16'd0);
    for (int i = 0; i < 6; i++) begin
      v = 8'(i * 37 + 5);
      sw_release(v, i < 5);
      if (i == 0) check("R10 scl released", 16'(scl_oe), 16'd0);
      recv_byte(1'b1, d);
      check("R4 byte", 16'(d), 16'(v));
      check((i < 5) ? "R4 ack status" : "R6 last status", 16'(status),
            (i < 5) ? 16'hB8 : 16'hC8);
    end
    sw_release(8'h00, 1'b1);
    recv_byte(1'b1, d);
    check("R7 detached reads ones", 16'(d), 16'hFF);
    check("R7 flag stays clear", 16'(si), 16'd0);
    bus_stop();

    // R8 acknowledge disabled, then resumed by repeated START
    ack_en = 1'b0;
    bus_start();
    send_byte({OWN, 1'b1}, ak);
    check("R8 no ack while disabled", 16'(ak), 16'd0);
    check("R8 no flag while disabled", 16'(si), 16'd0);
    ack_en = 1'b1;
    bus_start();
    send_byte({OWN, 1'b1}, ak);
    check("R8 ack after re-enable", 16'(ak), 16'd1);
    check("R8 status", 16'(status), 16'hA8);
    sw_release(8'h5A, 1'b0);
    recv_byte(1'b0, d);
    check("R5 nack status", 16'(status), 16'hC0);
    sw_release(8'h00, 1'b1);
    bus_stop();

    // R3 entry after lost arbitration
    arb = 1'b1;
    bus_start();
    send_byte({OWN, 1'b1}, ak);
    check("R3 status", 16'(status), 16'hB0);
    arb = 1'b0;
    sw_release(8'hC3, 1'b0);
    recv_byte(1'b1, d);
    check("R4 byte", 16'(d), 16'hC3);
    check("R6 last status", 16'(status), 16'hC8);
    sw_release(8'h00, 1'b1);
    check("R9 status", 16'(status), 16'hF8);
    bus_stop();

    summary();
    $finish;
  end
endmodule